// File: doc/BRIEF.md
# Serial Command Memory Loader

This block is a slave serial port that loads several on-chip memories from a host byte stream. The host pulls the active-low select line down and clocks bits in on the serial data pin. The block brings the three serial lines into the system clock domain and finds the rising edges of the serial clock. It packs the bits into bytes and reads them as one frame: a command byte, then a start address, then data words.

The command byte picks one of several target memories, each with its own depth. The two address bytes set the first word location. After that, every pair of data bytes becomes one write strobe on the chosen memory's enable line, with the address and word placed on a shared bus. The address steps up by one after each word. The run has no fixed length and ends only when the host releases select.

Writes that fall outside the chosen memory are dropped and raise an error flag. Unknown commands make the rest of the frame a no-op. Releasing select at any point throws away any unfinished byte or word.

Top module: `cmd_ram_writer`

## Requirements
- R1: While cs_ni is high, activity on sck_i and sdi_i has no effect: no byte is assembled and no strobe is raised.
- R2: Serial data is captured on each rising edge of sck_i, most significant bit first; within a data word the high byte arrives first.
- R3: The first byte of a frame selects the target. 45h drives mem_we_o[0] (depth 8), 46h drives mem_we_o[1] (depth 384) and 49h drives mem_we_o[2] (depth 16).
- R4: The two bytes after the command form the start address, high byte first.
- R5: Each following pair of bytes is one 16-bit word. Word k of the frame goes to start address plus k. A frame may hold any number of words.
- R6: Each accepted word gives one strobe, one clock cycle wide, once its low byte is complete. At most one bit of mem_we_o is high at a time, and mem_addr_o and mem_data_o carry the word's address and data in that cycle.
- R7: A word whose address is equal to or above the selected memory's depth raises no strobe and sets wr_err_o. wr_err_o stays set until the next falling edge of cs_ni, which clears it.
- R8: A command byte other than 45h, 46h or 49h causes no strobe for the rest of that frame.
- R9: Raising cs_ni discards any partial byte or word. The next frame starts again with a command byte.
- R10: After reset, mem_we_o is all zero and wr_err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| mem_we_o | output | NUM_MEM (3) | Per-memory write strobe |
| mem_addr_o | output | ADDR_W (16) | Write address, shared by all memories |
| mem_data_o | output | DATA_W (16) | Write data, shared by all memories |
| wr_err_o | output | 1 | Set when a write was dropped as out of range |

## Verification
The assertions assume that each phase of the serial clock lasts longer than the synchronizer and edge-detect delay. This keeps byte-complete pulses, and the strobes that follow them, at least eight system cycles apart. They also assume that select changes only while the serial clock is steady, so that no sampled edge lands on a select transition. The stimulus holds each serial clock phase for four system cycles and adds settle time around every select edge. Within those limits, the bench covers frames that cross a memory's depth, unknown commands, aborts in the middle of a byte and in the middle of a word, and serial traffic sent with select high.

// File: rtl/cmdwr_pkg.sv
package cmdwr_pkg;

  localparam int BYTE_W        = 8;
  localparam int DEPTH_FIELD_W = 32;

  // Default memory map: index 0..2, command byte and depth per index
  localparam int DEF_NUM_MEM = 3;
  localparam logic [DEF_NUM_MEM*BYTE_W-1:0] DEF_MEM_CMDS =
    {8'h49, 8'h46, 8'h45};
  localparam logic [DEF_NUM_MEM*DEPTH_FIELD_W-1:0] DEF_MEM_DEPTHS =
    {32'd16, 32'd384, 32'd8};

  typedef enum logic [1:0] {
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } frame_state_e;

endpackage

// File: rtl/cmdwr_sync.sv
module cmdwr_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/cmdwr_byte_rx.sv
module cmdwr_byte_rx
  import cmdwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sck_rise_i,
  input  logic              sdi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int BCNT_W = $clog2(BYTE_W);
  localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(BYTE_W - 1);

  logic [BCNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-2:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!active_i) begin
        bit_cnt_q <= '0;
      end else if (sck_rise_i) begin
        shift_q <= {shift_q[BYTE_W-3:0], sdi_i};
        if (bit_cnt_q == BIT_LAST) begin
          bit_cnt_q  <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {shift_q, sdi_i};
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  AST_BYTE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !byte_vld_o); // R1

  AST_BYTE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> bit_cnt_q == '0); // R9

endmodule

// File: rtl/cmdwr_cmd_decode.sv
module cmdwr_cmd_decode
  import cmdwr_pkg::*;
#(
  parameter int                                 NUM_MEM    = DEF_NUM_MEM,
  parameter logic [NUM_MEM*BYTE_W-1:0]          MEM_CMDS   = DEF_MEM_CMDS,
  parameter logic [NUM_MEM*DEPTH_FIELD_W-1:0]   MEM_DEPTHS = DEF_MEM_DEPTHS,
  parameter int                                 SEL_W      = 2
) (
  input  logic [BYTE_W-1:0]        cmd_i,
  output logic                     known_o,
  output logic [SEL_W-1:0]         sel_o,
  output logic [DEPTH_FIELD_W-1:0] depth_o
);

  logic [NUM_MEM-1:0] hit;

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_hit
    assign hit[g] = (cmd_i == MEM_CMDS[g*BYTE_W +: BYTE_W]);
  end

  // lowest index wins on duplicate codes
  always_comb begin
    known_o = 1'b0;
    sel_o   = '0;
    depth_o = '0;
    for (int i = NUM_MEM - 1; i >= 0; i--) begin
      if (hit[i]) begin
        known_o = 1'b1;
        sel_o   = SEL_W'(i);
        depth_o = MEM_DEPTHS[i*DEPTH_FIELD_W +: DEPTH_FIELD_W];
      end
    end
  end

endmodule

// File: rtl/cmdwr_frame_fsm.sv
module cmdwr_frame_fsm
  import cmdwr_pkg::*;
#(
  parameter int                               NUM_MEM    = DEF_NUM_MEM,
  parameter logic [NUM_MEM*BYTE_W-1:0]        MEM_CMDS   = DEF_MEM_CMDS,
  parameter logic [NUM_MEM*DEPTH_FIELD_W-1:0] MEM_DEPTHS = DEF_MEM_DEPTHS,
  parameter int                               ADDR_W     = 16,
  parameter int                               DATA_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NUM_MEM-1:0] mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_data_o,
  output logic               wr_err_o
);

  localparam int SEL_W       = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
  localparam int ADDR_BYTES  = ADDR_W / BYTE_W;
  localparam int WORD_BYTES  = DATA_W / BYTE_W;
  localparam int MAX_BYTES   = (ADDR_BYTES > WORD_BYTES) ? ADDR_BYTES : WORD_BYTES;
  localparam int CNT_W       = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BYTES - 1);

  frame_state_e               state_q;
  logic [CNT_W-1:0]           fcnt_q;
  logic [SEL_W-1:0]           sel_q;
  logic [DEPTH_FIELD_W-1:0]   depth_q;
  logic [ADDR_W-1:0]          wr_addr_q;
  logic [DATA_W-BYTE_W-1:0]   data_q;

  logic                       cmd_known;
  logic [SEL_W-1:0]           cmd_sel;
  logic [DEPTH_FIELD_W-1:0]   cmd_depth;
  logic [DATA_W-1:0]          word_next;
  logic                       in_range;
  logic [NUM_MEM-1:0]         sel_onehot;

  cmdwr_cmd_decode #(
    .NUM_MEM   (NUM_MEM),
    .MEM_CMDS  (MEM_CMDS),
    .MEM_DEPTHS(MEM_DEPTHS),
    .SEL_W     (SEL_W)
  ) u_cmd_decode (
    .cmd_i  (byte_i),
    .known_o(cmd_known),
    .sel_o  (cmd_sel),
    .depth_o(cmd_depth)
  );

  assign word_next  = {data_q, byte_i};
  assign in_range   = ({{(DEPTH_FIELD_W-ADDR_W){1'b0}}, wr_addr_q} < depth_q);
  assign sel_onehot = NUM_MEM'(1) << sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      fcnt_q     <= '0;
      sel_q      <= '0;
      depth_q    <= '0;
      wr_addr_q  <= '0;
      data_q     <= '0;
      mem_we_o   <= '0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      wr_err_o   <= 1'b0;
    end else begin
      mem_we_o <= '0;
      if (start_i) wr_err_o <= 1'b0;
      if (!active_i) begin
        state_q <= ST_CMD;
        fcnt_q  <= '0;
      end else if (byte_vld_i) begin
        unique case (state_q)
          ST_CMD: begin
            fcnt_q <= '0;
            if (cmd_known) begin
              sel_q   <= cmd_sel;
              depth_q <= cmd_depth;
              state_q <= ST_ADDR;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            wr_addr_q <= {wr_addr_q[ADDR_W-BYTE_W-1:0], byte_i};
            if (fcnt_q == ADDR_LAST) begin
              fcnt_q  <= '0;
              state_q <= ST_DATA;
            end else begin
              fcnt_q <= fcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (fcnt_q == WORD_LAST) begin
              fcnt_q    <= '0;
              wr_addr_q <= wr_addr_q + 1'b1;
              if (in_range) begin
                mem_we_o   <= sel_onehot;
                mem_addr_o <= wr_addr_q;
                mem_data_o <= word_next;
              end else begin
                wr_err_o <= 1'b1;
              end
            end else begin
              fcnt_q <= fcnt_q + 1'b1;
              data_q <= word_next[DATA_W-BYTE_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_we_o)); // R6

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_we_o) |=> !(|mem_we_o)); // R6

  AST_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> mem_we_o == '0); // R1

  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SKIP |=> mem_we_o == '0); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_err_o) |-> $past(byte_vld_i && state_q == ST_DATA)); // R7

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_chk
    AST_WE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o[g] |-> ({{(DEPTH_FIELD_W-ADDR_W){1'b0}}, mem_addr_o}
                       < MEM_DEPTHS[g*DEPTH_FIELD_W +: DEPTH_FIELD_W])); // R7
  end

endmodule

// File: rtl/cmd_ram_writer.sv
module cmd_ram_writer
  import cmdwr_pkg::*;
#(
  parameter int                               NUM_MEM     = DEF_NUM_MEM,
  parameter logic [NUM_MEM*BYTE_W-1:0]        MEM_CMDS    = DEF_MEM_CMDS,
  parameter logic [NUM_MEM*DEPTH_FIELD_W-1:0] MEM_DEPTHS  = DEF_MEM_DEPTHS,
  parameter int                               ADDR_W      = 16,
  parameter int                               DATA_W      = 16,
  parameter int                               SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic [NUM_MEM-1:0] mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_data_o,
  output logic               wr_err_o
);

  localparam int LINES = 3;

  logic [LINES-1:0] line_s;
  logic cs_s, sck_s, sdi_s;
  logic cs_q, sck_q;
  logic active, sck_rise, start;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;

  cmdwr_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   (line_s)
  );

  assign cs_s  = line_s[2];
  assign sck_s = line_s[1];
  assign sdi_s = line_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign active   = ~cs_s;
  assign sck_rise = active & sck_s & ~sck_q;
  assign start    = cs_q & ~cs_s;

  cmdwr_byte_rx u_byte_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sck_rise_i(sck_rise),
    .sdi_i     (sdi_s),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_val)
  );

  cmdwr_frame_fsm #(
    .NUM_MEM   (NUM_MEM),
    .MEM_CMDS  (MEM_CMDS),
    .MEM_DEPTHS(MEM_DEPTHS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .start_i   (start),
    .byte_vld_i(byte_vld),
    .byte_i    (byte_val),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o),
    .wr_err_o  (wr_err_o)
  );

  AST_ERR_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !wr_err_o); // R7

endmodule

// File: tb/cmd_ram_writer_bench.sv
module cmd_ram_writer_bench;

  localparam int HALF = 4;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic [2:0]  we;
  logic [15:0] addr;
  logic [15:0] data;
  logic        err;

  int total = 0;
  int bad = 0;
  int strobes = 0;
  logic [2:0] prev_we = '0;

  int exp_idx[$];
  int exp_addr[$];
  int exp_data[$];

  always #4 clk = ~clk;

  cmd_ram_writer u_cmd_ram_writer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .sck_i     (sck),
    .sdi_i     (sdi),
    .mem_we_o  (we),
    .mem_addr_o(addr),
    .mem_data_o(data),
    .wr_err_o  (err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cmd_index(input logic [7:0] c);
    case (c)
      8'h45:   return 0;
      8'h46:   return 1;
      8'h49:   return 2;
      default: return -1;
    endcase
  endfunction

  function automatic int idx_depth(input int i);
    case (i)
      0:       return 8;
      1:       return 384;
      default: return 16;
    endcase
  endfunction

  // strobe monitor: every clock, compare against the model's queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (|we) begin
        int pos;
        pos = -1;
        strobes++;
        for (int b = 0; b < 3; b++) if (we[b]) pos = b;
        chk($countones(we) == 1, "R6 onehot", we, 0);
        chk(prev_we == '0, "R6 single cycle", prev_we, 0);
        if (exp_idx.size() == 0) begin
          chk(1'b0, "R1/R8/R9 unexpected strobe", we, 0);
        end else begin
          chk(pos == exp_idx[0], "R3 target", pos, exp_idx[0]);
          chk(addr == exp_addr[0], "R4/R5 address", addr, exp_addr[0]);
          chk(data == exp_data[0], "R2 data", data, exp_data[0]);
          void'(exp_idx.pop_front());
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
        end
      end
      prev_we = we;
    end
  end

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic open_frame();
    sck = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_frame();
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic int word_of(input int seed, input int k);
    return ((seed + k * 16'h1357) ^ (k << 11)) & 16'hFFFF;
  endfunction

  task automatic run_frame(input logic [7:0] cmd, input int start, input int nwords,
                           input int seed, input string req);
    int idx;
    bit exp_err;
    idx = cmd_index(cmd);
    exp_err = 1'b0;
    open_frame();
    send_bits(32'(cmd), 8);
    send_bits(32'(start), 16);
    for (int k = 0; k < nwords; k++) begin
      int a, w;
      a = (start + k) & 16'hFFFF;
      w = word_of(seed, k);
      if (idx >= 0) begin
        if (a < idx_depth(idx)) begin
          exp_idx.push_back(idx);
          exp_addr.push_back(a);
          exp_data.push_back(w);
        end else begin
          exp_err = 1'b1;
        end
      end
      send_bits(32'(w), 16);
    end
    close_frame();
    chk(exp_idx.size() == 0, {req, " all words written"}, exp_idx.size(), 0);
    chk(err == exp_err, {"R7 error flag after ", req}, err, exp_err);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(we == '0, "R10 strobes in reset", we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(we == '0, "R10 strobes after reset", we, 0);
    chk(err == 1'b0, "R10 error after reset", err, 0);

    // R3 R4 R5: each target, plain runs
    run_frame(8'h45, 3, 3, 16'h8001, "R3 seq mem");
    run_frame(8'h49, 0, 5, 16'h00FF, "R3 offset mem");
    // R4 high address byte, R7 crossing the coefficient depth
    run_frame(8'h46, 382, 4, 16'hC3A5, "R4 R7 coef crossing");
    // R7 clear on next select, ends exactly at depth
    run_frame(8'h49, 14, 2, 16'h7E01, "R7 clear offset tail");
    run_frame(8'h45, 16'h0100, 2, 16'h5A5A, "R7 far address");
    // R8 unknown command followed by valid-looking bytes
    run_frame(8'h47, 0, 3, 16'h1111, "R8 unknown cmd");
    run_frame(8'h00, 0, 2, 16'h2222, "R8 zero cmd");

    // R1: full frame sent with select high
    s0 = strobes;
    sck = 1'b0;
    send_bits(32'h4600_00, 24);
    send_bits(32'hBEEF, 16);
    repeat (10) @(negedge clk);
    chk(strobes == s0, "R1 no strobe with cs high", strobes - s0, 0);
    run_frame(8'h45, 0, 2, 16'hF00D, "R1 frame after idle traffic");

    // R9: abort in mid word
    open_frame();
    send_bits(32'h46, 8);
    send_bits(32'h0010, 16);
    exp_idx.push_back(1); exp_addr.push_back(16'h0010); exp_data.push_back(16'h1234);
    send_bits(32'h1234, 16);
    send_bits(32'hAB5, 11);
    close_frame();
    chk(exp_idx.size() == 0, "R9 one word before abort", exp_idx.size(), 0);
    // R9: abort in mid command byte, next frame must decode cleanly
    s0 = strobes;
    open_frame();
    send_bits(32'h09, 5);
    close_frame();
    chk(strobes == s0, "R9 partial byte no strobe", strobes - s0, 0);
    run_frame(8'h49, 7, 3, 16'h3C3C, "R9 frame after partial");

    // R5 long unbounded run
    run_frame(8'h46, 0, 64, 16'h0F0F, "R5 long run");

    chk(exp_idx.size() == 0, "R5 queue drained", exp_idx.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule